// File: doc/BRIEF.md
# Hardware Monitor Limit Status Registers

This block gathers the readings of a channel-sequencing monitor and turns them into three 8-bit read-only status registers. Each reading arrives with its own valid strobe. In the cycle the strobe is high, the block compares the reading against the limits held for that channel and updates that channel's status bit. A channel without a strobe keeps its previous bit. The analog-input register holds eight window comparisons. The fan register holds eight high-limit comparisons on tachometer counts. A third register collects the remaining results: the internal temperature, the auxiliary analog input and the battery voltage, plus event flags for the thermal mode, the automatic fan control, chassis intrusion and one general-purpose pin.

Two hysteresis trackers watch a set of signed temperature channels. Channel 0 is the internal sensor. The first tracker engages thermal mode when any channel rises above its thermal limit. That channel stays hot until its reading drops to five degrees below the limit. The second tracker applies the same rule against each channel's fan-start threshold, and so switches the automatic fan on and off. Each change of either mode raises a one-shot event flag. The event flags are sticky, and a host read of the third register clears them. The window bits are simply refreshed on each conversion.

Top module: `hm_status_regs`

## Requirements
- R1: While `rst` is high at a clock edge, every status bit is cleared at that edge, and so are both mode outputs. After reset every read selector returns 00h.
- R2: For analog input i, when `ain_vld[i]` is high at an edge, bit i of the analog register (selector 0) becomes 1 if the unsigned reading is above its high limit or below its low limit, and 0 otherwise.
- R3: For fan i, when `fan_vld[i]` is high at an edge, bit i of the fan register (selector 1) becomes 1 only when the unsigned count is above its high limit. Fan channels have no low limit.
- R4: In the misc register (selector 2), three bits are signed or unsigned window comparisons, each updated on its own strobe. Bit 0 is the internal temperature: temperature channel 0, compared signed against `itemp_hi`/`itemp_lo`. Bit 1 is the auxiliary input and bit 2 is the battery voltage, both compared unsigned.
- R5: A channel whose strobe is low at an edge keeps its status bit, whatever its data or limit inputs do.
- R6: A temperature channel becomes hot when a strobed signed reading exceeds its limit. It becomes cool when a strobed reading is at or below the limit minus 5, where the subtraction saturates at -128. Otherwise it holds its state. `therm_active` is the OR of the channels' thermal hot states, and `fan_auto_on` is the same OR taken against the `fan_tmin` thresholds.
- R7: Misc bit 4 is set at the edge where `therm_active` changes in either direction. It is not set again while the mode holds.
- R8: Misc bit 5 is set at the edge where `fan_auto_on` changes in either direction. It is not set again while the mode holds.
- R9: Misc bit 3 is set at any edge where `intr_in` is high, and it stays set until it is cleared by a read.
- R10: When `gpio_dir_out` is 0, misc bit 6 is set at any edge where `gpio_pin_in` XOR `gpio_act_low` is 1, and it stays set until it is cleared by a read.
- R11: When `gpio_dir_out` is 1, a `gpio_wr_en` edge loads `gpio_wr_val` into misc bit 6, and a read does not clear that bit. `gpio_oe` equals `gpio_dir_out`, and `gpio_pin_out` equals bit 6 XOR `gpio_act_low`.
- R12: Misc bit 7 always reads 0, and selector 3 reads 00h. An edge with `rd_en` high and selector 2 clears the sticky bits 3, 4, 5 and 6 (input mode), but a set condition present at that same edge wins. Window bits are left untouched by the read.
- R13: `rd_data` is combinational from the registers, so a read returns the value held before its own clearing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ain_vld | input | 8 | Per-channel analog conversion strobe |
| ain_data | input | 64 | Analog readings, 8 bits per channel |
| ain_hi | input | 64 | Analog high limits |
| ain_lo | input | 64 | Analog low limits |
| fan_vld | input | 8 | Per-fan count strobe |
| fan_data | input | 64 | Fan tachometer counts |
| fan_hi | input | 64 | Fan high limits |
| vbat_vld | input | 1 | Battery reading strobe |
| vbat_data | input | 8 | Battery reading |
| vbat_hi | input | 8 | Battery high limit |
| vbat_lo | input | 8 | Battery low limit |
| aux_vld | input | 1 | Auxiliary analog strobe |
| aux_data | input | 8 | Auxiliary analog reading |
| aux_hi | input | 8 | Auxiliary high limit |
| aux_lo | input | 8 | Auxiliary low limit |
| temp_vld | input | 3 | Temperature strobes; channel 0 is internal |
| temp_data | input | 24 | Signed temperatures, 1 degree per LSB |
| therm_lim | input | 24 | Signed thermal-mode limits per channel |
| fan_tmin | input | 24 | Signed fan-start thresholds per channel |
| itemp_hi | input | 8 | Internal temperature high limit (signed) |
| itemp_lo | input | 8 | Internal temperature low limit (signed) |
| intr_in | input | 1 | Chassis intrusion detect |
| gpio_dir_out | input | 1 | 1 selects output mode for the general pin |
| gpio_act_low | input | 1 | 1 selects active-low polarity |
| gpio_pin_in | input | 1 | Sampled pin level |
| gpio_wr_en | input | 1 | Write strobe for the pin's status bit |
| gpio_wr_val | input | 1 | Value written to the pin's status bit |
| gpio_pin_out | output | 1 | Pin drive level |
| gpio_oe | output | 1 | Pin output enable |
| rd_en | input | 1 | Read strobe (clears sticky bits of selector 2) |
| rd_sel | input | 2 | 0 analog, 1 fan, 2 misc, 3 none |
| rd_data | output | 8 | Selected status register |
| therm_active | output | 1 | Thermal mode state |
| fan_auto_on | output | 1 | Automatic fan state |

## Verification
The bench builds the block with its defaults: eight analog channels, eight fans and three temperature channels. With three temperature channels, one channel can keep a mode engaged while another cools, which shows that an event fires only on a change of the OR and never on one channel's own transitions. The signed 8-bit temperature width makes a limit near -128 meaningful, so the saturating disengage threshold can be told apart from a wrapped one. Readings inside the signed window that would fail an unsigned compare separate the two compare modes of the misc register.

// File: rtl/hm_pkg.sv
package hm_pkg;

    localparam int DW       = 8;   // analog and fan reading width
    localparam int TW       = 8;   // signed temperature width
    localparam int HYST_DEG = 5;   // disengage margin in degrees

    typedef enum logic [1:0] {
        SEL_AIN  = 2'd0,
        SEL_FAN  = 2'd1,
        SEL_MISC = 2'd2,
        SEL_NONE = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic spare;   // bit 7
        logic gpio;    // bit 6
        logic afc;     // bit 5
        logic therm;   // bit 4
        logic intr;    // bit 3
        logic vbat;    // bit 2
        logic aux;     // bit 1
        logic itemp;   // bit 0
    } misc_t;

    function automatic logic win_u(input logic [DW-1:0] v,
                                   input logic [DW-1:0] hi,
                                   input logic [DW-1:0] lo);
        return (v > hi) || (v < lo);
    endfunction

    function automatic logic win_s(input logic signed [TW-1:0] v,
                                   input logic signed [TW-1:0] hi,
                                   input logic signed [TW-1:0] lo);
        return (v > hi) || (v < lo);
    endfunction

    function automatic logic signed [TW-1:0] sat_dec(input logic signed [TW-1:0] v,
                                                     input int d);
        int r;
        r = int'(v) - d;
        if (r < -(2 ** (TW - 1))) r = -(2 ** (TW - 1));
        return TW'(r);
    endfunction

endpackage

// File: rtl/hm_window_bank.sv
module hm_window_bank #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   vld,
    input  logic [N*W-1:0] data,
    input  logic [N*W-1:0] hi,
    input  logic [N*W-1:0] lo,
    output logic [N-1:0]   stat_o
);

    for (genvar i = 0; i < N; i++) begin : g_ch
        logic [W-1:0] d, h, l;
        assign d = data[i*W +: W];
        assign h = hi[i*W +: W];
        assign l = lo[i*W +: W];

        always_ff @(posedge clk) begin
            if (rst)         stat_o[i] <= 1'b0;
            else if (vld[i]) stat_o[i] <= (d > h) || (d < l);
        end

        // R5
        hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
            !vld[i] |=> $stable(stat_o[i]));
    end

endmodule

// File: rtl/hm_hyst_mode.sv
module hm_hyst_mode
    import hm_pkg::*;
#(
    parameter int N = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    vld,
    input  logic [N*TW-1:0] data,
    input  logic [N*TW-1:0] lim,
    output logic            mode_o,
    output logic            evt_o
);

    logic [N-1:0] hot_q, hot_d;
    logic         mode_q;

    for (genvar i = 0; i < N; i++) begin : g_ch
        logic signed [TW-1:0] t, l, off;
        assign t   = data[i*TW +: TW];
        assign l   = lim[i*TW +: TW];
        assign off = sat_dec(l, HYST_DEG);
        assign hot_d[i] = !vld[i]  ? hot_q[i] :
                          (t > l)  ? 1'b1     :
                          (t <= off) ? 1'b0   : hot_q[i];

        // R6
        hot_forces_mode_chk: assert property (@(posedge clk) disable iff (rst)
            (vld[i] && (t > l)) |=> mode_o);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hot_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            hot_q  <= hot_d;
            mode_q <= |hot_d;
        end
    end

    assign mode_o = mode_q;
    assign evt_o  = (|hot_d) != mode_q;

endmodule

// File: rtl/hm_status_regs.sv
module hm_status_regs
    import hm_pkg::*;
#(
    parameter int N_AIN  = 8,
    parameter int N_FAN  = 8,
    parameter int N_TEMP = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_AIN-1:0]    ain_vld,
    input  logic [N_AIN*DW-1:0] ain_data,
    input  logic [N_AIN*DW-1:0] ain_hi,
    input  logic [N_AIN*DW-1:0] ain_lo,
    input  logic [N_FAN-1:0]    fan_vld,
    input  logic [N_FAN*DW-1:0] fan_data,
    input  logic [N_FAN*DW-1:0] fan_hi,
    input  logic                vbat_vld,
    input  logic [DW-1:0]       vbat_data,
    input  logic [DW-1:0]       vbat_hi,
    input  logic [DW-1:0]       vbat_lo,
    input  logic                aux_vld,
    input  logic [DW-1:0]       aux_data,
    input  logic [DW-1:0]       aux_hi,
    input  logic [DW-1:0]       aux_lo,
    input  logic [N_TEMP-1:0]   temp_vld,
    input  logic [N_TEMP*TW-1:0] temp_data,
    input  logic [N_TEMP*TW-1:0] therm_lim,
    input  logic [N_TEMP*TW-1:0] fan_tmin,
    input  logic [TW-1:0]       itemp_hi,
    input  logic [TW-1:0]       itemp_lo,
    input  logic                intr_in,
    input  logic                gpio_dir_out,
    input  logic                gpio_act_low,
    input  logic                gpio_pin_in,
    input  logic                gpio_wr_en,
    input  logic                gpio_wr_val,
    output logic                gpio_pin_out,
    output logic                gpio_oe,
    input  logic                rd_en,
    input  logic [1:0]          rd_sel,
    output logic [7:0]          rd_data,
    output logic                therm_active,
    output logic                fan_auto_on
);

    localparam logic [DW*N_FAN-1:0] FAN_NO_LO = '0;

    logic [N_AIN-1:0] stat_ain;
    logic [N_FAN-1:0] stat_fan;
    misc_t            misc_q, misc_d;
    logic             therm_evt, afc_evt, clr;
    rd_sel_e          sel;

    assign sel = rd_sel_e'(rd_sel);
    assign clr = rd_en && (sel == SEL_MISC);

    hm_window_bank #(.N(N_AIN), .W(DW)) u_ain (
        .clk(clk), .rst(rst), .vld(ain_vld), .data(ain_data),
        .hi(ain_hi), .lo(ain_lo), .stat_o(stat_ain));

    // a zero low limit on unsigned counts leaves only the high check
    hm_window_bank #(.N(N_FAN), .W(DW)) u_fan (
        .clk(clk), .rst(rst), .vld(fan_vld), .data(fan_data),
        .hi(fan_hi), .lo(FAN_NO_LO), .stat_o(stat_fan));

    hm_hyst_mode #(.N(N_TEMP)) u_therm (
        .clk(clk), .rst(rst), .vld(temp_vld), .data(temp_data),
        .lim(therm_lim), .mode_o(therm_active), .evt_o(therm_evt));

    hm_hyst_mode #(.N(N_TEMP)) u_afc (
        .clk(clk), .rst(rst), .vld(temp_vld), .data(temp_data),
        .lim(fan_tmin), .mode_o(fan_auto_on), .evt_o(afc_evt));

    always_comb begin
        misc_d = misc_q;
        if (temp_vld[0])
            misc_d.itemp = win_s(temp_data[TW-1:0], itemp_hi, itemp_lo);
        if (aux_vld)  misc_d.aux  = win_u(aux_data, aux_hi, aux_lo);
        if (vbat_vld) misc_d.vbat = win_u(vbat_data, vbat_hi, vbat_lo);
        misc_d.intr  = (misc_q.intr  & ~clr) | intr_in;
        misc_d.therm = (misc_q.therm & ~clr) | therm_evt;
        misc_d.afc   = (misc_q.afc   & ~clr) | afc_evt;
        if (gpio_dir_out)
            misc_d.gpio = gpio_wr_en ? gpio_wr_val : misc_q.gpio;
        else
            misc_d.gpio = (misc_q.gpio & ~clr) | (gpio_pin_in ^ gpio_act_low);
        misc_d.spare = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) misc_q <= '0;
        else     misc_q <= misc_d;
    end

    always_comb begin
        rd_data = '0;
        case (sel)
            SEL_AIN:  rd_data[N_AIN-1:0] = stat_ain;
            SEL_FAN:  rd_data[N_FAN-1:0] = stat_fan;
            SEL_MISC: rd_data = misc_q;
            default:  rd_data = '0;
        endcase
    end

    assign gpio_oe      = gpio_dir_out;
    assign gpio_pin_out = misc_q.gpio ^ gpio_act_low;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (rd_data == 8'h00 && !therm_active && !fan_auto_on));

    for (genvar i = 0; i < N_FAN; i++) begin : g_fan_chk
        // R3
        fan_not_over_chk: assert property (@(posedge clk) disable iff (rst)
            (fan_vld[i] && (fan_data[i*DW +: DW] <= fan_hi[i*DW +: DW])) |=> !stat_fan[i]);
    end

    // R7
    therm_flag_on_change_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(misc_q.therm) |-> (therm_active != $past(therm_active)));

    // R9
    intr_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !intr_in) |=> !misc_q.intr);

    // R11
    gpio_write_chk: assert property (@(posedge clk) disable iff (rst)
        (gpio_dir_out && gpio_wr_en) |=> (misc_q.gpio == $past(gpio_wr_val)));

    // R12
    spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) || (sel == SEL_MISC) |-> (sel == SEL_NONE) ? (rd_data == 8'h00) : !rd_data[7]);

endmodule

// File: tb/hm_status_regs_tb.sv
module hm_status_regs_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [7:0]       ain_vld = '0;
    logic [7:0][7:0]  ain_d = '0, ain_h = '0, ain_l = '0;
    logic [7:0]       fan_vld = '0;
    logic [7:0][7:0]  fan_d = '0, fan_h = '0;
    logic             vbat_vld = 0, aux_vld = 0;
    logic [7:0]       vbat_d = 0, vbat_h = 0, vbat_l = 0, aux_d = 0, aux_h = 0, aux_l = 0;
    logic [2:0]       temp_vld = '0;
    logic [2:0][7:0]  temp_d = '0, tlim = '0, tmin = '0;
    logic [7:0]       it_hi = 0, it_lo = 0;
    logic             intr = 0, g_dir = 0, g_al = 0, g_pin = 0, g_we = 0, g_wv = 0;
    logic             rd_en = 0;
    logic [1:0]       rd_sel = 0;
    logic [1:0]       rsel = 0;
    logic             g_out, g_oe, t_act, f_on;
    logic [7:0]       rd_data;

    hm_status_regs dut_i (
        .clk(clk), .rst(rst),
        .ain_vld(ain_vld), .ain_data(ain_d), .ain_hi(ain_h), .ain_lo(ain_l),
        .fan_vld(fan_vld), .fan_data(fan_d), .fan_hi(fan_h),
        .vbat_vld(vbat_vld), .vbat_data(vbat_d), .vbat_hi(vbat_h), .vbat_lo(vbat_l),
        .aux_vld(aux_vld), .aux_data(aux_d), .aux_hi(aux_h), .aux_lo(aux_l),
        .temp_vld(temp_vld), .temp_data(temp_d), .therm_lim(tlim), .fan_tmin(tmin),
        .itemp_hi(it_hi), .itemp_lo(it_lo), .intr_in(intr),
        .gpio_dir_out(g_dir), .gpio_act_low(g_al), .gpio_pin_in(g_pin),
        .gpio_wr_en(g_we), .gpio_wr_val(g_wv), .gpio_pin_out(g_out), .gpio_oe(g_oe),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .therm_active(t_act), .fan_auto_on(f_on));

    int checks = 0, fails = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_ain[8], m_fan[8];
    int m_it = 0, m_aux = 0, m_vb = 0, m_intr = 0, m_th = 0, m_afc = 0, m_gp = 0;
    int th_hot[3], af_hot[3];
    int th_mode = 0, af_mode = 0;

    function automatic int upd_hot(int hot, int t, int l);
        int off;
        off = l - 5;
        if (off < -128) off = -128;
        if (t > l) return 1;
        if (t <= off) return 0;
        return hot;
    endfunction

    task automatic model_step();
        int clr, nm, t;
        if (rst) begin
            for (int i = 0; i < 8; i++) begin m_ain[i] = 0; m_fan[i] = 0; end
            for (int i = 0; i < 3; i++) begin th_hot[i] = 0; af_hot[i] = 0; end
            m_it = 0; m_aux = 0; m_vb = 0; m_intr = 0; m_th = 0; m_afc = 0; m_gp = 0;
            th_mode = 0; af_mode = 0;
            return;
        end
        clr = (rd_en && rsel == 2) ? 1 : 0;
        for (int i = 0; i < 8; i++) begin
            if (ain_vld[i]) m_ain[i] = (ain_d[i] > ain_h[i] || ain_d[i] < ain_l[i]) ? 1 : 0;
            if (fan_vld[i]) m_fan[i] = (fan_d[i] > fan_h[i]) ? 1 : 0;
        end
        for (int i = 0; i < 3; i++) if (temp_vld[i]) begin
            t = $signed(temp_d[i]);
            th_hot[i] = upd_hot(th_hot[i], t, $signed(tlim[i]));
            af_hot[i] = upd_hot(af_hot[i], t, $signed(tmin[i]));
        end
        if (temp_vld[0]) begin
            t = $signed(temp_d[0]);
            m_it = (t > $signed(it_hi) || t < $signed(it_lo)) ? 1 : 0;
        end
        if (aux_vld)  m_aux = (aux_d > aux_h || aux_d < aux_l) ? 1 : 0;
        if (vbat_vld) m_vb  = (vbat_d > vbat_h || vbat_d < vbat_l) ? 1 : 0;
        nm = (th_hot[0] | th_hot[1] | th_hot[2]);
        m_th = ((clr ? 0 : m_th) | ((nm != th_mode) ? 1 : 0));
        th_mode = nm;
        nm = (af_hot[0] | af_hot[1] | af_hot[2]);
        m_afc = ((clr ? 0 : m_afc) | ((nm != af_mode) ? 1 : 0));
        af_mode = nm;
        m_intr = (clr ? 0 : m_intr) | intr;
        if (g_dir) begin
            if (g_we) m_gp = g_wv;
        end else begin
            m_gp = (clr ? 0 : m_gp) | (g_pin ^ g_al);
        end
    endtask

    function automatic logic [7:0] exp_reg(int s);
        logic [7:0] b = '0;
        case (s)
            0: for (int i = 0; i < 8; i++) b[i] = m_ain[i][0];
            1: for (int i = 0; i < 8; i++) b[i] = m_fan[i][0];
            2: b = {1'b0, m_gp[0], m_afc[0], m_th[0], m_intr[0], m_vb[0], m_aux[0], m_it[0]};
            default: b = '0;
        endcase
        return b;
    endfunction

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    // one clock: model follows the inputs present at the edge, then all outputs compared
    task automatic cyc();
        rd_sel = rsel;
        @(posedge clk);
        #2;
        model_step();
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            chk($sformatf("reg%0d", s), rd_data, exp_reg(s));
        end
        rd_sel = rsel;
        chk("therm_active", t_act, th_mode);
        chk("fan_auto_on", f_on, af_mode);
        chk("gpio_oe", g_oe, g_dir);
        chk("gpio_pin_out", g_out, m_gp ^ g_al);
    endtask

    task automatic temp_in(int ch, int v);
        temp_vld = '0;
        temp_vld[ch] = 1'b1;
        temp_d[ch] = 8'(v);
        cyc();
        temp_vld = '0;
    endtask

    task automatic read_misc();
        rd_en = 1; rsel = 2;
        cyc();
        rd_en = 0;
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog run did not complete");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset with busy inputs
        cur_req = "R1";
        intr = 1; ain_vld = '1; ain_d = '1;
        repeat (3) cyc();
        intr = 0; ain_vld = '0; ain_d = '0;
        rst = 0;
        cyc();

        // R2: analog window compare
        cur_req = "R2";
        for (int i = 0; i < 8; i++) begin ain_h[i] = 8'd200; ain_l[i] = 8'd50; end
        ain_vld = '1;
        ain_d = {8'd201, 8'd200, 8'd50, 8'd49, 8'd0, 8'd255, 8'd128, 8'd51};
        cyc();
        ain_d = {8'd100, 8'd10, 8'd220, 8'd60, 8'd70, 8'd80, 8'd255, 8'd1};
        cyc();

        // R5: no strobe, data and limits move, bits hold
        cur_req = "R5";
        ain_vld = '0;
        ain_d = '0; ain_h = '0;
        repeat (2) cyc();
        ain_vld = 8'b0000_0101; ain_l = '0;
        cyc();
        ain_vld = '0;

        // R3: fan high-only compare
        cur_req = "R3";
        for (int i = 0; i < 8; i++) fan_h[i] = 8'd100;
        fan_vld = '1;
        fan_d = {8'd0, 8'd101, 8'd100, 8'd255, 8'd1, 8'd99, 8'd150, 8'd0};
        cyc();
        fan_vld = 8'b1111_0000; fan_d = '0;
        cyc();
        fan_vld = '0;

        // R4: misc window bits, signed internal temperature
        cur_req = "R4";
        it_hi = 8'sd50; it_lo = -8'sd10;
        tlim = {3{8'sd100}}; tmin = {3{8'sd100}};
        temp_in(0, -5);
        temp_in(0, -11);
        temp_in(0, 51);
        temp_in(0, 50);
        aux_h = 8'd90; aux_l = 8'd30; vbat_h = 8'd180; vbat_l = 8'd150;
        aux_vld = 1; vbat_vld = 1; aux_d = 8'd29; vbat_d = 8'd160;
        cyc();
        aux_d = 8'd60; vbat_d = 8'd181;
        cyc();
        aux_vld = 0; vbat_vld = 0; aux_d = 8'd0; vbat_d = 8'd0;
        cyc();

        // R6 / R7: thermal hysteresis with several channels
        cur_req = "R7";
        tlim = {8'sd40, 8'sd60, 8'sd100};
        temp_in(1, 61);
        cyc();
        read_misc();
        cur_req = "R6";
        temp_in(1, 58);
        temp_in(1, 56);
        temp_in(2, 45);
        temp_in(1, 55);
        cur_req = "R7";
        cyc();
        temp_in(2, 35);
        read_misc();
        temp_in(2, 36);
        // saturated disengage threshold near the bottom of the range
        cur_req = "R6";
        tlim[2] = -8'sd125;
        temp_in(2, -124);
        temp_in(2, -127);
        temp_in(2, -128);
        read_misc();

        // R8: automatic fan control events
        cur_req = "R8";
        tlim = {3{8'sd120}};
        tmin = {8'sd30, 8'sd30, 8'sd30};
        temp_in(1, 31);
        temp_in(1, 40);
        read_misc();
        temp_in(1, 26);
        temp_in(1, 25);
        read_misc();

        // R9: intrusion latch
        cur_req = "R9";
        intr = 1; cyc(); intr = 0;
        repeat (2) cyc();
        read_misc();
        cyc();

        // R10: general pin as active-low input
        cur_req = "R10";
        g_dir = 0; g_al = 1; g_pin = 1;
        repeat (2) cyc();
        g_pin = 0; cyc(); g_pin = 1;
        cyc();
        read_misc();
        cyc();

        // R11: general pin as output
        cur_req = "R11";
        g_dir = 1; g_al = 0;
        g_we = 1; g_wv = 1; cyc(); g_we = 0;
        read_misc();
        g_al = 1; cyc();
        g_we = 1; g_wv = 0; cyc(); g_we = 0;
        g_dir = 0; g_al = 0; g_pin = 0;

        // R12: read coincides with new events; window bits untouched
        cur_req = "R12";
        intr = 1; cyc();
        rd_en = 1; rsel = 2; cyc(); rd_en = 0;
        intr = 0;
        read_misc();
        rsel = 3; rd_en = 1; intr = 1; cyc(); rd_en = 0; intr = 0;

        // R13: the read returns the value before its clearing edge
        cur_req = "R13";
        rsel = 2;
        intr = 1; cyc(); intr = 0;
        rd_sel = 2; #1;
        chk("pre-clear read", rd_data[3], 1);
        read_misc();
        rd_sel = 2; #1;
        chk("post-clear read", rd_data[3], 0);

        // mixed traffic against the model
        cur_req = "R5";
        for (int k = 0; k < 400; k++) begin
            ain_vld = 8'($urandom); ain_d = 64'({$urandom, $urandom});
            fan_vld = 8'($urandom); fan_d = 64'({$urandom, $urandom});
            temp_vld = 3'($urandom); temp_d = 24'($urandom);
            aux_vld = 1'($urandom); aux_d = 8'($urandom);
            vbat_vld = 1'($urandom); vbat_d = 8'($urandom);
            intr = ($urandom % 8) == 0; g_pin = 1'($urandom);
            rd_en = 1'($urandom); rsel = 2'($urandom);
            cyc();
        end
        rd_en = 0;
        cyc();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule